// File: doc/BRIEF.md
# Masked-write GPIO bank with pin interrupts

This block is a bank of 32 general-purpose pins on a simple 32-bit register bus. Every pin has an output value, a direction bit and a two-stage input synchroniser. Every pin also has interrupt logic. That logic has an enable, a mask, a trigger kind (edge or level), a polarity, a raw status bit and a masked status bit. Edge status is latched and is cleared by writing a one to the pin's bit in the end-of-interrupt register. One combined interrupt line is high while any masked status bit is set.

The control registers come in pairs. The low register of a pair covers pins 0 to 15, and the high register, 4 bytes above it, covers pins 16 to 31. A write never rewrites a whole register. The upper 16 bits of the write data choose which of the lower 16 bits take the new value, so software can change one pin without reading the register first.

The bus has no handshake. A write takes effect at the clock edge on which it is presented. Read data is a combinational function of the address.

Top module: `gpio_bank_mw`

Byte addresses of the control pairs (low, high):

| Function | Low | High |
|---|---|---|
| output value | 0x00 | 0x04 |
| direction | 0x08 | 0x0C |
| interrupt enable | 0x10 | 0x14 |
| interrupt mask | 0x18 | 0x1C |
| trigger kind | 0x20 | 0x24 |
| polarity | 0x28 | 0x2C |

Other addresses:

| Address | Access | Contents |
|---|---|---|
| 0x40 | read | raw status |
| 0x44 | read | masked status |
| 0x4C | write | end-of-interrupt; reads as 0 |
| 0x70 | read | synchronised pin levels |
| 0x78 | read | version constant |

## Requirements
- R1: After reset, the output-value, direction, enable, trigger-kind and polarity registers all read 0. Both mask registers read 0x0000FFFF, the interrupt line is low and pin_oe is 0.
- R2: A write to a control register changes bit n (n < 16) to wdata[n] only where wdata[n+16] is 1; every other bit keeps its old value. Reads of a control register return its 16 bits in [15:0] with zeros in [31:16].
- R3: Each high register, 4 bytes above its low partner, holds pins 16 to 31 in its bits [15:0]. A write to one half never changes the other half.
- R4: pin_oe equals the direction bits (1 = output). pin_out equals output value AND direction, so a pin driven as an input outputs 0.
- R5: A read of 0x70 returns all 32 pin levels after the two-flop synchroniser.
- R6: A read of 0x78 returns 0x0101157C.
- R7: With trigger kind 0 (level), the raw status bit is 1 while the synchronised level equals the polarity bit (1 = high, 0 = low). It follows the pin continuously, and end-of-interrupt writes do not change it.
- R8: With trigger kind 1 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) sets a latched raw status bit. An edge in the other direction does not set it. Writing 1 to that pin's bit at 0x4C clears the latch, and zero bits in that write leave the latch alone.
- R9: If an edge and an end-of-interrupt write for the same pin land in the same cycle, the status bit stays set.
- R10: A pin whose enable bit is 0 reports raw status 0.
- R11: Masked status at 0x44 is raw status AND NOT mask (mask 1 = blocked). The interrupt line is high exactly while masked status is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr |
| pin_in | input | 32 | pin levels from the pads |
| pin_out | output | 32 | output value to the pads |
| pin_oe | output | 32 | output enable per pin |
| irq | output | 1 | combined interrupt |

## Verification
The hardest case to reach is the collision in R9. An end-of-interrupt write must arrive at the same clock edge that latches a new edge, and that edge appears only after the two synchroniser stages and the registered previous-level copy. The bench changes the pin on a falling clock edge and waits one more falling edge. It then presents the end-of-interrupt write, so that the write is captured at the third rising edge after the pin change, which is the edge at which the latch sets. The collision is staged after the latch has first been cleared by an ordinary end-of-interrupt write, so a design in which the clear wins ends with the bit at 0 and is caught.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        CR_DATA = 3'd0,
        CR_DIR  = 3'd1,
        CR_IEN  = 3'd2,
        CR_MASK = 3'd3,
        CR_KIND = 3'd4,
        CR_POL  = 3'd5
    } ctrl_e;

    localparam int NUM_CTRL   = 6;
    localparam int CTRL_STEP  = 8;
    localparam int HI_OFFSET  = 4;

    localparam logic [7:0] ADR_RAW  = 8'h40;
    localparam logic [7:0] ADR_MSKD = 8'h44;
    localparam logic [7:0] ADR_EOI  = 8'h4C;
    localparam logic [7:0] ADR_INP  = 8'h70;
    localparam logic [7:0] ADR_VER  = 8'h78;

    localparam logic [31:0] VERSION_WORD = 32'h0101157C;

endpackage

// File: rtl/gpio_split_reg.sv
module gpio_split_reg #(
    parameter int HALF_W = 16,
    parameter logic [2*HALF_W-1:0] RST_VAL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_lo,
    input  logic                we_hi,
    input  logic [2*HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] q
);
    logic [HALF_W-1:0] sel;
    logic [HALF_W-1:0] val;

    assign sel = wdata[2*HALF_W-1:HALF_W];
    assign val = wdata[HALF_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            if (we_lo)
                q[HALF_W-1:0] <= (q[HALF_W-1:0] & ~sel) | (val & sel);
            if (we_hi)
                q[2*HALF_W-1:HALF_W] <= (q[2*HALF_W-1:HALF_W] & ~sel) | (val & sel);
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] st [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                st[i] <= '0;
        end else begin
            st[0] <= din;
            for (int i = 1; i < STAGES; i++)
                st[i] <= st[i-1];
        end
    end

    assign dout = st[STAGES-1];
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic edge_mode,
    input  logic pol,
    input  logic eoi,
    output logic raw
);
    logic prv;
    logic latched;
    logic hit;

    assign hit = edge_mode & (pol ? (lvl & ~prv) : (~lvl & prv));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv     <= 1'b0;
            latched <= 1'b0;
        end else begin
            prv <= lvl;
            if (!en)
                latched <= 1'b0;
            else if (hit)
                latched <= 1'b1;
            else if (eoi)
                latched <= 1'b0;
        end
    end

    assign raw = en & (edge_mode ? latched : (lvl == pol));
endmodule

// File: rtl/gpio_bank_mw.sv
module gpio_bank_mw
    import gpio_bank_pkg::*;
#(
    parameter int HALF_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*HALF_W-1:0] bus_wdata,
    output logic [2*HALF_W-1:0] bus_rdata,
    input  logic [2*HALF_W-1:0] pin_in,
    output logic [2*HALF_W-1:0] pin_out,
    output logic [2*HALF_W-1:0] pin_oe,
    output logic                irq
);
    localparam int NPINS    = 2 * HALF_W;
    localparam int IDX_MASK = int'(CR_MASK);

    logic             wr_cyc;
    logic [NPINS-1:0] cq [NUM_CTRL];
    logic [NPINS-1:0] data_v, dir_v, en_v, mask_v, kind_v, pol_v;
    logic [NPINS-1:0] sync_v;
    logic [NPINS-1:0] eoi_v;
    logic [NPINS-1:0] raw_st;
    logic [NPINS-1:0] msk_st;

    assign wr_cyc = bus_sel & bus_wr;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
        gpio_split_reg #(
            .HALF_W (HALF_W),
            .RST_VAL((k == IDX_MASK) ? {NPINS{1'b1}} : {NPINS{1'b0}})
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we_lo(wr_cyc && (bus_addr == ADDR_W'(k * CTRL_STEP))),
            .we_hi(wr_cyc && (bus_addr == ADDR_W'(k * CTRL_STEP + HI_OFFSET))),
            .wdata(bus_wdata),
            .q    (cq[k])
        );
    end

    assign data_v = cq[int'(CR_DATA)];
    assign dir_v  = cq[int'(CR_DIR)];
    assign en_v   = cq[int'(CR_IEN)];
    assign mask_v = cq[int'(CR_MASK)];
    assign kind_v = cq[int'(CR_KIND)];
    assign pol_v  = cq[int'(CR_POL)];

    gpio_sync #(
        .WIDTH (NPINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_v)
    );

    assign eoi_v = (wr_cyc && (bus_addr == ADDR_W'(ADR_EOI))) ? bus_wdata : '0;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio_irq_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (sync_v[p]),
            .en       (en_v[p]),
            .edge_mode(kind_v[p]),
            .pol      (pol_v[p]),
            .eoi      (eoi_v[p]),
            .raw      (raw_st[p])
        );
    end

    assign msk_st  = raw_st & ~mask_v;
    assign irq     = |msk_st;
    assign pin_oe  = dir_v;
    assign pin_out = data_v & dir_v;

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (bus_addr == ADDR_W'(k * CTRL_STEP))
                bus_rdata = {{HALF_W{1'b0}}, cq[k][HALF_W-1:0]};
            if (bus_addr == ADDR_W'(k * CTRL_STEP + HI_OFFSET))
                bus_rdata = {{HALF_W{1'b0}}, cq[k][NPINS-1:HALF_W]};
        end
        if (bus_addr == ADDR_W'(ADR_RAW))  bus_rdata = raw_st;
        if (bus_addr == ADDR_W'(ADR_MSKD)) bus_rdata = msk_st;
        if (bus_addr == ADDR_W'(ADR_INP))  bus_rdata = sync_v;
        if (bus_addr == ADDR_W'(ADR_VER))  bus_rdata = NPINS'(VERSION_WORD);
    end
endmodule

// File: rtl/gpio_bank_mw_chk.sv
module gpio_bank_mw_chk
    import gpio_bank_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [HALF_W-1:0]   wdata_hi,
    input logic [2*HALF_W-1:0] bus_rdata,
    input logic [2*HALF_W-1:0] pin_out,
    input logic [2*HALF_W-1:0] pin_oe,
    input logic                irq,
    input logic [2*HALF_W-1:0] raw,
    input logic [2*HALF_W-1:0] masked,
    input logic [2*HALF_W-1:0] mask_q,
    input logic [2*HALF_W-1:0] en_q
);
    p_out_only_when_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~en_q) == '0);

    p_masked_subset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (masked & (mask_q | ~raw)) == '0);

    p_irq_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (masked != '0));

    p_no_select_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(8'h18) && wdata_hi == '0)
        |=> $stable(mask_q[HALF_W-1:0]));

    p_version_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_VER)) |-> (bus_rdata == (2*HALF_W)'(VERSION_WORD)));
endmodule

bind gpio_bank_mw gpio_bank_mw_chk #(
    .HALF_W(HALF_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdata_hi (bus_wdata[2*HALF_W-1:HALF_W]),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .raw      (raw_st),
    .masked   (msk_st),
    .mask_q   (mask_v),
    .en_q     (en_v)
);

// File: tb/gpio_bank_mw_test.sv
module gpio_bank_mw_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_mw uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [79:0] VEC [11] = '{
        {8'h00, 32'h0005_0005, 8'h00, 32'h0000_0005},
        {8'h00, 32'h0001_0000, 8'h00, 32'h0000_0004},
        {8'h00, 32'h0000_FFFF, 8'h00, 32'h0000_0004},
        {8'h04, 32'h8000_8000, 8'h04, 32'h0000_8000},
        {8'h08, 32'hFFFF_00F0, 8'h08, 32'h0000_00F0},
        {8'h0C, 32'h0003_0001, 8'h0C, 32'h0000_0001},
        {8'h18, 32'h00FF_0000, 8'h18, 32'h0000_FF00},
        {8'h1C, 32'hFFFF_1234, 8'h1C, 32'h0000_1234},
        {8'h28, 32'h0F0F_FFFF, 8'h28, 32'h0000_0F0F},
        {8'h00, 32'h0000_0000, 8'h04, 32'h0000_8000},
        {8'h00, 32'h0010_0010, 8'h00, 32'h0000_0014}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd_chk("R1 data lo", 8'h00, 32'h0);
        rd_chk("R1 dir hi", 8'h0C, 32'h0);
        rd_chk("R1 enable lo", 8'h10, 32'h0);
        rd_chk("R1 kind hi", 8'h24, 32'h0);
        rd_chk("R1 polarity lo", 8'h28, 32'h0);
        rd_chk("R1 mask lo", 8'h18, 32'h0000_FFFF);
        rd_chk("R1 mask hi", 8'h1C, 32'h0000_FFFF);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        rd_chk("R6 version", 8'h78, 32'h0101_157C);
        rd_chk("R5 input after reset", 8'h70, 32'h0);

        // R2, R3 masked-write table
        for (int i = 0; i < 11; i++) begin
            logic [79:0] v;
            v = VEC[i];
            wr(v[79:72], v[71:40]);
            rd_chk("R2,R3 table", v[39:32], v[31:0]);
        end
        // R4 pin drive: data lo 0x0014 hi 0x8000, dir lo 0x00F0 hi 0x0001
        @(negedge clk);
        chk("R4 pin_oe", pin_oe, 32'h0001_00F0);
        chk("R4 pin_out", pin_out, 32'h0000_0010);
        chk("R11 irq with no enables", {31'h0, irq}, 32'h0);

        // Interrupt tests from a fresh reset
        do_reset();
        wr(8'h20, 32'h0003_0003);   // pins 0,1 edge
        wr(8'h28, 32'h000F_0005);   // pin0 rising, pin1 falling, pin2 high, pin3 low
        wr(8'h10, 32'h000F_000F);   // enable pins 0..3
        wr(8'h18, 32'h0007_0000);   // unmask pins 0..2
        wr(8'h24, 32'h0002_0002);   // pin17 edge
        wr(8'h2C, 32'h0002_0002);   // pin17 rising, left disabled
        settle();
        rd_chk("R7 level low active", 8'h40, 32'h0000_0008);
        rd_chk("R11 masked blocked", 8'h44, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        @(negedge clk);
        pin_in[0] = 1'b1; pin_in[2] = 1'b1; pin_in[17] = 1'b1;
        settle();
        rd_chk("R5 input port", 8'h70, 32'h0002_0005);
        rd_chk("R8,R10 raw after rise", 8'h40, 32'h0000_000D);
        rd_chk("R11 masked after rise", 8'h44, 32'h0000_0005);
        chk("R11 irq high", {31'h0, irq}, 32'h1);

        @(negedge clk);
        pin_in[0] = 1'b0;
        settle();
        rd_chk("R8 latch holds", 8'h40, 32'h0000_000D);
        wr(8'h4C, 32'h0000_0008);
        settle();
        rd_chk("R7 eoi ignored by level", 8'h40, 32'h0000_000D);
        wr(8'h4C, 32'h0000_0001);
        settle();
        rd_chk("R8 eoi clears edge", 8'h40, 32'h0000_000C);
        rd_chk("R11 masked after eoi", 8'h44, 32'h0000_0004);

        @(negedge clk);
        pin_in[2] = 1'b0;
        settle();
        rd_chk("R7 level follows pin", 8'h40, 32'h0000_0008);
        chk("R11 irq drops", {31'h0, irq}, 32'h0);

        @(negedge clk);
        pin_in[1] = 1'b1;
        settle();
        rd_chk("R8 wrong direction", 8'h40, 32'h0000_0008);
        @(negedge clk);
        pin_in[1] = 1'b0;
        settle();
        rd_chk("R8 falling edge", 8'h40, 32'h0000_000A);
        chk("R11 irq falling", {31'h0, irq}, 32'h1);
        wr(8'h4C, 32'h0000_0003);
        settle();
        rd_chk("R8 clear before collision", 8'h40, 32'h0000_0008);

        // R9: eoi captured at the same edge that latches the new rise
        @(negedge clk);
        pin_in[0] = 1'b1;
        @(negedge clk);
        wr(8'h4C, 32'h0000_0001);
        settle();
        rd_chk("R9 edge wins over eoi", 8'h40, 32'h0000_0009);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule